// File: doc/BRIEF.md
# Fixed-Priority AXI Address Channel Switch

This block routes the address channel of an AXI interconnect joining four masters to four slave ports plus a fifth default port. Every master's address runs through its own decoder, which raises exactly one port request whenever that master holds VALID. An address that falls inside no configured window goes to the default port, so every transfer is still accepted by some port and then completes.

Each port has its own arbiter. The arbiter picks among the masters that request it, with master 0 always winning over higher-numbered masters. It keeps its grant until the address handshake completes and can be held by a locked sequence. The grant is a one-hot select over the masters. It gates the winner's address, control and lock fields onto the port and gates the port's READY back to that master only.

Each master may have one transaction outstanding. After its address is accepted, its requests are masked until the bench or the surrounding interconnect pulses that master's completion input. Masters that target different ports are served in the same cycle.

Top module: `axi_addr_switch`

## Requirements
- R1: With the default map, port k (k = 0..3) owns addresses k*0x1000_0000 through k*0x1000_0000 + 0x00FF_FFFF. Any other address goes to port 4, the default port. A request is raised only while the master's VALID is high.
- R2: When several eligible masters request an idle, unlocked port, the lowest-numbered master is granted.
- R3: A port's select is one-hot or zero. Only the granted master's address, control and lock are forwarded, gated by its VALID. An ungranted port shows VALID low and all fields zero.
- R4: A port's READY reaches only its granted master, and every other master's READY is low.
- R5: A request to an idle port is granted at the next clock edge, so the port shows it one cycle after the master raises VALID. The grant and the forwarded fields hold until the handshake. The port is then idle for one cycle before the next grant.
- R6: A handshake with the lock bit set locks the port to that master. Requests from all other masters to the port are ignored until the owner completes a handshake with the lock bit clear.
- R7: After a master's address is accepted, its requests are ignored until a one-cycle pulse on its completion input. The completion input has no effect while the master has nothing outstanding.
- R8: During reset no port is granted, no VALID is forwarded and no READY is returned, even if masters hold VALID.
- R9: Masters that address different ports are granted and accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_valid | input | NM | Address VALID per master |
| m_addr | input | NM x AW | Address per master |
| m_ctrl | input | NM x CW | Burst length, size and type per master, carried as is |
| m_lock | input | NM | Lock request per master |
| m_ready | output | NM | Address READY back to each master |
| m_done | input | NM | One-cycle pulse when a master's outstanding transaction has finished |
| s_valid | output | NS+1 | Forwarded VALID per port; the last port is the default port |
| s_addr | output | (NS+1) x AW | Forwarded address per port |
| s_ctrl | output | (NS+1) x CW | Forwarded control per port |
| s_lock | output | (NS+1) x 1 | Forwarded lock bit per port |
| s_ready | input | NS+1 | Address READY from each port |

## Verification
The embedded properties assume that each master follows the AXI rule of holding VALID, address, control and lock unchanged from the moment VALID rises until READY is seen. They also assume that a master pulses its completion input only after its address has been accepted. The bench's master driver keeps to both rules: it raises VALID only from its transaction queue and drops it only in the cycle after a handshake. It times completion pulses from a per-master countdown that starts at that handshake. Slave READY is free to toggle on any cycle, because the properties place no limit on it.

// File: rtl/axsw_pkg.sv
// Shared defaults for the address channel switch.
// Assumes: the default address map places one 16 MiB window per slave port
// at the start of each 256 MiB segment.
package axsw_pkg;
    localparam int unsigned DEF_MASTERS = 4;
    localparam int unsigned DEF_SLAVES  = 4;
    localparam int unsigned DEF_ADDR_W  = 32;
    // burst length (8) + beat size (3) + burst type (2)
    localparam int unsigned DEF_CTRL_W  = 13;
    localparam logic [31:0] DEF_STRIDE  = 32'h1000_0000;
    localparam logic [31:0] DEF_SPAN    = 32'h0100_0000;
endpackage

// File: rtl/axsw_decode.sv
// Per-master address decoder.
// Raises exactly one port request while VALID is high: the lowest-numbered
// window that matches, or the default port (index NS) when none matches.
// Assumes each SIZE entry is a power of two and BASE is aligned to it.
module axsw_decode #(
    parameter int unsigned AW = 32,
    parameter int unsigned NS = 4,
    parameter logic [NS-1:0][AW-1:0] BASE = '0,
    parameter logic [NS-1:0][AW-1:0] SIZE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic [AW-1:0] addr,
    output logic [NS:0]   req
);
    logic [NS-1:0] hit;
    logic [NS-1:0] first;

    // Window compare: clear the offset bits, then compare with the base.
    generate
        for (genvar k = 0; k < NS; k++) begin : g_win
            assign hit[k] = (addr & ~(SIZE[k] - AW'(1))) == BASE[k];
        end
    endgenerate

    // Keep only the lowest matching window; fall back to the default port.
    always_comb begin
        first = hit & (~hit + NS'(1));
        req   = '0;
        if (valid) begin
            if (hit == '0) req[NS] = 1'b1;
            else           req[NS-1:0] = first;
        end
    end

    // R1: a valid address always selects exactly one port.
    p_decode_one_port_r1: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $onehot(req));
endmodule

// File: rtl/axsw_arb.sv
// Switching control unit for one port: fixed-priority arbiter with lock.
// The grant is registered. It is taken only while the port is idle and
// released at the edge that completes the port handshake. A handshake
// carrying lock makes the winner the owner; while the port is owned, only
// the owner is eligible.
// Assumes the granted master holds VALID until READY.
module axsw_arb #(
    parameter int unsigned NM = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NM-1:0] req,
    input  logic [NM-1:0] lock_req,
    input  logic          port_valid,
    input  logic          port_ready,
    output logic [NM-1:0] gnt
);
    logic [NM-1:0] gnt_q;
    logic [NM-1:0] owner_q;
    logic [NM-1:0] elig;
    logic [NM-1:0] pick;
    logic          hs;
    logic          hs_locked;

    // Filter by lock ownership, then isolate the lowest-numbered requester.
    always_comb begin
        elig      = (owner_q == '0) ? req : (req & owner_q);
        pick      = elig & (~elig + NM'(1));
        hs        = port_valid & port_ready;
        hs_locked = |(gnt_q & lock_req);
    end

    // Grant and lock-owner state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_q   <= '0;
            owner_q <= '0;
        end else if (gnt_q != '0) begin
            if (hs) begin
                gnt_q   <= '0;
                owner_q <= hs_locked ? gnt_q : '0;
            end
        end else begin
            gnt_q <= pick;
        end
    end

    assign gnt = gnt_q;

    // R3: the path select never names two masters.
    p_select_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_q));
    // R5: a pending handshake keeps the grant in place.
    p_grant_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (port_valid && !port_ready) |=> $stable(gnt_q));
    // R2: an idle unlocked port grants the lowest-numbered requester.
    p_fixed_priority_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_q == '0 && owner_q == '0 && req != '0)
        |=> (gnt_q == ($past(req) & (~$past(req) + NM'(1)))));
    // R6: a locked port is granted to its owner only.
    p_lock_owner_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_q != '0 && gnt_q != '0) |-> (gnt_q == owner_q));
endmodule

// File: rtl/axsw_busy.sv
// Outstanding-transaction tracker, one bit per master.
// A bit sets when the master's address is accepted and clears on its
// completion pulse. A completion pulse while the bit is clear is ignored.
module axsw_busy #(
    parameter int unsigned NM = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NM-1:0] accepted,
    input  logic [NM-1:0] done,
    output logic [NM-1:0] busy
);
    logic [NM-1:0] busy_q;

    // Set on acceptance, clear on completion of an outstanding transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= '0;
        else        busy_q <= (busy_q | accepted) & ~(busy_q & done);
    end

    assign busy = busy_q;

    generate
        for (genvar i = 0; i < NM; i++) begin : g_chk
            // R7: acceptance always leaves the master outstanding.
            p_accept_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
                accepted[i] |=> busy_q[i]);
            // R7: completion frees the master.
            p_done_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (busy_q[i] && done[i]) |=> !busy_q[i]);
        end
    endgenerate
endmodule

// File: rtl/axi_addr_switch.sv
// Address channel switch: NM masters to NS slave ports plus a default port.
// Holds the per-master decoders, one arbiter per port, the outstanding
// tracker and the AND-OR path select in both directions.
// Assumes AXI-compliant masters (VALID and payload held until READY) and
// at most one outstanding transaction per master.
module axi_addr_switch
    import axsw_pkg::*;
#(
    parameter int unsigned NM = DEF_MASTERS,
    parameter int unsigned NS = DEF_SLAVES,
    parameter int unsigned AW = DEF_ADDR_W,
    parameter int unsigned CW = DEF_CTRL_W,
    parameter logic [NS-1:0][AW-1:0] BASE =
        {3 * DEF_STRIDE, 2 * DEF_STRIDE, DEF_STRIDE, 32'h0000_0000},
    parameter logic [NS-1:0][AW-1:0] SIZE = {NS{DEF_SPAN}}
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NM-1:0]            m_valid,
    input  logic [NM-1:0][AW-1:0]    m_addr,
    input  logic [NM-1:0][CW-1:0]    m_ctrl,
    input  logic [NM-1:0]            m_lock,
    output logic [NM-1:0]            m_ready,
    input  logic [NM-1:0]            m_done,
    output logic [NS:0]              s_valid,
    output logic [NS:0][AW-1:0]      s_addr,
    output logic [NS:0][CW-1:0]      s_ctrl,
    output logic [NS:0]              s_lock,
    input  logic [NS:0]              s_ready
);
    localparam int unsigned NP = NS + 1;

    logic [NM-1:0][NP-1:0] dec_req;
    logic [NP-1:0][NM-1:0] port_req;
    logic [NP-1:0][NM-1:0] gnt;
    logic [NM-1:0]         busy;
    logic [NM-1:0]         accepted;

    generate
        for (genvar m = 0; m < NM; m++) begin : g_mst
            axsw_decode #(.AW(AW), .NS(NS), .BASE(BASE), .SIZE(SIZE)) u_dec (
                .clk   (clk),
                .rst_n (rst_n),
                .valid (m_valid[m]),
                .addr  (m_addr[m]),
                .req   (dec_req[m])
            );
        end
        for (genvar p = 0; p < NP; p++) begin : g_port
            axsw_arb #(.NM(NM)) u_arb (
                .clk        (clk),
                .rst_n      (rst_n),
                .req        (port_req[p]),
                .lock_req   (m_lock),
                .port_valid (s_valid[p]),
                .port_ready (s_ready[p]),
                .gnt        (gnt[p])
            );
        end
    endgenerate

    axsw_busy #(.NM(NM)) u_busy (
        .clk      (clk),
        .rst_n    (rst_n),
        .accepted (accepted),
        .done     (m_done),
        .busy     (busy)
    );

    // Transpose decoder bits into per-port requests, masking busy masters.
    always_comb begin
        for (int p = 0; p < NP; p++)
            for (int m = 0; m < NM; m++)
                port_req[p][m] = dec_req[m][p] & ~busy[m];
    end

    // Forward path: AND-OR select of the granted master onto each port.
    always_comb begin
        for (int p = 0; p < NP; p++) begin
            s_valid[p] = |(gnt[p] & m_valid);
            s_lock[p]  = |(gnt[p] & m_lock);
            s_addr[p]  = '0;
            s_ctrl[p]  = '0;
            for (int m = 0; m < NM; m++) begin
                s_addr[p] = s_addr[p] | ({AW{gnt[p][m]}} & m_addr[m]);
                s_ctrl[p] = s_ctrl[p] | ({CW{gnt[p][m]}} & m_ctrl[m]);
            end
        end
    end

    // Return path: each port's READY gated by the same select bit.
    always_comb begin
        m_ready = '0;
        for (int m = 0; m < NM; m++)
            for (int p = 0; p < NP; p++)
                m_ready[m] = m_ready[m] | (gnt[p][m] & s_ready[p]);
        accepted = m_valid & m_ready;
    end

    generate
        for (genvar m = 0; m < NM; m++) begin : g_mchk
            // R4: READY only reaches a master that is presenting an address.
            p_ready_to_requester_r4: assert property (@(posedge clk) disable iff (!rst_n)
                m_ready[m] |-> m_valid[m]);
            // R7: an accepted master is not accepted again the next cycle.
            p_single_outstanding_r7: assert property (@(posedge clk) disable iff (!rst_n)
                accepted[m] |=> !m_ready[m]);
        end
        for (genvar p = 0; p < NP; p++) begin : g_pchk
            // R5: a stalled port keeps its address steady.
            p_port_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (s_valid[p] && !s_ready[p]) |=> (s_valid[p] && $stable(s_addr[p])));
        end
    endgenerate
endmodule

// File: tb/sim_axi_addr_switch.sv
// Bench: queued master drivers, a behavioural per-cycle reference model
// and directed scenarios for decode, priority, lock, outstanding and
// concurrency.
module sim_axi_addr_switch;
    localparam int CLK_NS = 10;
    localparam int NM = 4;
    localparam int NP = 5;
    localparam int AW = 32;
    localparam int CW = 13;
    localparam int QD = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NM-1:0]         m_valid = '0;
    logic [NM-1:0][AW-1:0] m_addr  = '0;
    logic [NM-1:0][CW-1:0] m_ctrl  = '0;
    logic [NM-1:0]         m_lock  = '0;
    logic [NM-1:0]         m_ready;
    logic [NM-1:0]         m_done  = '0;
    logic [NP-1:0]         s_valid;
    logic [NP-1:0][AW-1:0] s_addr;
    logic [NP-1:0][CW-1:0] s_ctrl;
    logic [NP-1:0]         s_lock;
    logic [NP-1:0]         s_ready = '1;

    int n_chk = 0;
    int n_bad = 0;

    axi_addr_switch u0 (
        .clk(clk), .rst_n(rst_n),
        .m_valid(m_valid), .m_addr(m_addr), .m_ctrl(m_ctrl), .m_lock(m_lock),
        .m_ready(m_ready), .m_done(m_done),
        .s_valid(s_valid), .s_addr(s_addr), .s_ctrl(s_ctrl), .s_lock(s_lock),
        .s_ready(s_ready)
    );

    always #(CLK_NS / 2) clk = ~clk;

    // Reference model state (integers, -1 = none).
    int mg [NP];
    int own [NP];
    bit mbusy [NM];
    bit hs_seen [NM];
    int cyc = 0;

    // Handshake log taken from the ports.
    int lg_m [512];
    int lg_p [512];
    int lg_c [512];
    int lg_n = 0;

    // Master transaction queues and completion countdowns.
    logic [AW-1:0] qa [NM][QD];
    bit            ql [NM][QD];
    int qh [NM];
    int qt [NM];
    int dly [NM];
    int wcnt [NM];
    bit rnd_ready = 1'b0;

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic int ref_port(input logic [31:0] a);
        if (a[31:28] < 4'd4 && a[27:24] == 4'd0) return int'(a[31:28]);
        return 4;
    endfunction

    task automatic push(input int m, input logic [31:0] a, input bit l);
        qa[m][qt[m] % QD] = a;
        ql[m][qt[m] % QD] = l;
        qt[m]++;
    endtask

    // Master and slave driver: acts right after the falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            m_done = '0;
        end else begin
            for (int m = 0; m < NM; m++) begin
                m_done[m] = 1'b0;
                if (hs_seen[m]) begin
                    m_valid[m] = 1'b0;
                    qh[m]++;
                    wcnt[m] = dly[m];
                end else if (wcnt[m] > 0) begin
                    wcnt[m]--;
                    if (wcnt[m] == 0) m_done[m] = 1'b1;
                end
                if (!m_valid[m] && qh[m] != qt[m]) begin
                    m_valid[m] = 1'b1;
                    m_addr[m]  = qa[m][qh[m] % QD];
                    m_lock[m]  = ql[m][qh[m] % QD];
                    m_ctrl[m]  = qa[m][qh[m] % QD][CW-1:0] ^ CW'(m);
                end
            end
            if (rnd_ready) s_ready = NP'($urandom);
        end
    end

    // Reference model: compare outputs, log handshakes, advance state.
    always @(negedge clk) begin
        #2;
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) begin mg[p] = -1; own[p] = -1; end
            for (int m = 0; m < NM; m++) begin mbusy[m] = 1'b0; hs_seen[m] = 1'b0; end
        end else begin
            logic [NM-1:0] er;
            bit nb [NM];
            cyc++;
            er = '0;
            for (int p = 0; p < NP; p++) begin
                logic ev, el;
                logic [AW-1:0] ea;
                logic [CW-1:0] ec;
                ev = 1'b0; el = 1'b0; ea = '0; ec = '0;
                if (mg[p] >= 0) begin
                    ev = m_valid[mg[p]]; el = m_lock[mg[p]];
                    ea = m_addr[mg[p]];  ec = m_ctrl[mg[p]];
                    if (s_ready[p]) er[mg[p]] = 1'b1;
                end
                chk(s_valid[p] == ev && s_addr[p] == ea && s_lock[p] == el,
                    $sformatf("R3 forward port %0d {lock,valid,addr}", p),
                    {30'd0, s_lock[p], s_valid[p], s_addr[p]}, {30'd0, el, ev, ea});
                chk(s_ctrl[p] == ec, $sformatf("R3 control port %0d", p),
                    64'(s_ctrl[p]), 64'(ec));
            end
            chk(m_ready == er, "R4 ready return", 64'(m_ready), 64'(er));
            // Log handshakes seen at the ports.
            for (int p = 0; p < NP; p++) begin
                if (s_valid[p] && s_ready[p]) begin
                    for (int m = 0; m < NM; m++) begin
                        if (m_ready[m] && m_valid[m] && ref_port(m_addr[m]) == p && lg_n < 512) begin
                            lg_m[lg_n] = m; lg_p[lg_n] = p; lg_c[lg_n] = cyc; lg_n++;
                        end
                    end
                end
            end
            // Next state.
            for (int m = 0; m < NM; m++) begin
                nb[m] = mbusy[m];
                hs_seen[m] = m_valid[m] & er[m];
            end
            for (int p = 0; p < NP; p++) begin
                if (mg[p] >= 0) begin
                    if (m_valid[mg[p]] && s_ready[p]) begin
                        nb[mg[p]] = 1'b1;
                        own[p] = m_lock[mg[p]] ? mg[p] : -1;
                        mg[p] = -1;
                    end
                end else begin
                    bit found;
                    found = 1'b0;
                    for (int m = 0; m < NM; m++) begin
                        if (!found && m_valid[m] && !mbusy[m] && ref_port(m_addr[m]) == p
                            && (own[p] < 0 || own[p] == m)) begin
                            mg[p] = m;
                            found = 1'b1;
                        end
                    end
                end
            end
            for (int m = 0; m < NM; m++) begin
                if (mbusy[m] && m_done[m]) nb[m] = 1'b0;
                mbusy[m] = nb[m];
            end
        end
    end

    task automatic wait_idle();
        bit idle;
        idle = 1'b0;
        while (!idle) begin
            @(posedge clk);
            idle = (m_valid == '0) && (m_done == '0);
            for (int m = 0; m < NM; m++)
                if (qh[m] != qt[m] || wcnt[m] != 0) idle = 1'b0;
        end
        repeat (3) @(posedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d_addr [6];
        int d_port [6];
        int b;
        for (int m = 0; m < NM; m++) begin qh[m] = 0; qt[m] = 0; dly[m] = 1; wcnt[m] = 0; end

        // R8: reset blocks everything even with a master presenting VALID.
        m_valid[0] = 1'b1;
        m_addr[0]  = 32'h0000_0040;
        repeat (3) @(negedge clk);
        #3;
        chk(s_valid == '0, "R8 no forward in reset", 64'(s_valid), 64'd0);
        chk(m_ready == '0, "R8 no ready in reset", 64'(m_ready), 64'd0);
        m_valid = '0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (2) @(posedge clk); #1;

        // R1: decode windows and default port, master 1.
        d_addr[0] = 32'h0000_0010; d_port[0] = 0;
        d_addr[1] = 32'h1000_0000; d_port[1] = 1;
        d_addr[2] = 32'h20FF_FFFC; d_port[2] = 2;
        d_addr[3] = 32'h3000_4000; d_port[3] = 3;
        d_addr[4] = 32'h0100_0000; d_port[4] = 4;
        d_addr[5] = 32'hF000_0000; d_port[5] = 4;
        dly[1] = 2;
        b = lg_n;
        for (int i = 0; i < 6; i++) push(1, d_addr[i], 1'b0);
        wait_idle();
        chk(lg_n == b + 6, "R1 decode handshake count", 64'(lg_n - b), 64'd6);
        for (int i = 0; i < 6; i++)
            chk(lg_p[b + i] == d_port[i] && lg_m[b + i] == 1,
                $sformatf("R1 decode of %h", d_addr[i]), 64'(lg_p[b + i]), 64'(d_port[i]));

        // R2 and R5: four masters race for port 2 while it stalls.
        @(posedge clk); #1;
        s_ready = '0;
        b = lg_n;
        for (int m = NM - 1; m >= 0; m--) push(m, 32'h2000_0100 + 32'(m * 4), 1'b0);
        repeat (5) @(posedge clk); #1;
        chk(s_valid[2] == 1'b1 && s_addr[2] == 32'h2000_0100, "R5 grant held while stalled",
            64'(s_addr[2]), 64'h2000_0100);
        s_ready = '1;
        wait_idle();
        for (int i = 0; i < NM; i++)
            chk(lg_m[b + i] == i, $sformatf("R2 priority order slot %0d", i), 64'(lg_m[b + i]), 64'(i));

        // R6: master 2 locks port 1; master 0 must wait for the release.
        dly[2] = 3;
        b = lg_n;
        push(2, 32'h1000_0000, 1'b1);
        while (lg_n == b) @(posedge clk);
        #1;
        push(0, 32'h1000_0040, 1'b0);
        push(2, 32'h1000_0004, 1'b1);
        push(2, 32'h1000_0008, 1'b0);
        wait_idle();
        chk(lg_m[b] == 2 && lg_m[b + 1] == 2 && lg_m[b + 2] == 2 && lg_m[b + 3] == 0,
            "R6 locked sequence order",
            64'({lg_m[b][3:0], lg_m[b + 1][3:0], lg_m[b + 2][3:0], lg_m[b + 3][3:0]}), 64'h2220);

        // R7: second transfer of master 3 waits for the completion pulse.
        dly[3] = 10;
        b = lg_n;
        push(3, 32'h0000_1000, 1'b0);
        push(3, 32'h0000_2000, 1'b0);
        wait_idle();
        chk(lg_c[b + 1] - lg_c[b] == dly[3] + 3, "R7 one outstanding gap",
            64'(lg_c[b + 1] - lg_c[b]), 64'(dly[3] + 3));

        // R9: four masters to four ports accepted together.
        for (int m = 0; m < NM; m++) dly[m] = 1;
        b = lg_n;
        for (int m = 0; m < NM; m++) push(m, (32'(m) << 28) | 32'h0000_0100, 1'b0);
        wait_idle();
        chk(lg_n == b + 4 && lg_c[b] == lg_c[b + 3], "R9 parallel acceptance",
            64'(lg_c[b + 3] - lg_c[b]), 64'd0);

        // Random traffic with toggling slave READY, compared every cycle.
        rnd_ready = 1'b1;
        for (int i = 0; i < 400; i++) begin
            int m, r;
            logic [31:0] a;
            m = $urandom_range(0, NM - 1);
            r = $urandom_range(0, 4);
            dly[m] = $urandom_range(1, 4);
            a = $urandom;
            if (r < 4) a = {4'(r), 4'h0, a[23:2], 2'b00};
            else       a = {4'h4, a[27:2], 2'b00};
            if (qt[m] - qh[m] < 8) push(m, a, 1'b0);
            repeat ($urandom_range(0, 3)) @(posedge clk);
            #1;
        end
        wait_idle();
        rnd_ready = 1'b0;
        @(negedge clk);
        s_ready = '1;
        repeat (2) @(posedge clk);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule